// File: doc/BRIEF.md
# Dual-Channel Converter Serial Response Model

This block models the digital output side of a converter that samples two analog channels at the same instant and returns both results over two serial data lines that run in parallel. A host lowers the chip select input to start a frame and toggles the serial clock. The block answers on both lines in lockstep. It first drives zeros for a fixed conversion window. It then sends each channel's two's complement result, most significant bit first. After the last bit it sends zeros until chip select rises. Outside a frame the lines are released, which is modelled by a per-line output enable.

The two result words come from a stimulus port. They are captured when chip select falls, so a frame always carries the values present at its start. A track flag reports whether the front-end track-and-hold is sampling. The flag is low from the start of a frame until the conversion window closes. The result width is a parameter. With W result bits, the last bit appears on falling edge 14 + W.

Top module: `dual_adc_serial_out`

## Requirements
- R1: On chip select falling, both output enables go high and both data lines read 0 before any serial clock falling edge.
- R2: During falling edges 1 to 14 of a frame, both data lines stay 0 and the track flag stays low.
- R3: On falling edge 15 the track flag goes high, and each data line carries bit W-1 (the sign bit) of its channel's word.
- R4: On falling edge 15 + j, for j from 0 to W-1, line A carries bit W-1-j of word A and line B carries bit W-1-j of word B, both in the same cycle.
- R5: After the bit 0 edge (edge 14 + W) and until the frame ends, both data lines read 0.
- R6: When chip select is high, both output enables are 0, both data lines read 0 and the track flag is 1. Every frame counts its falling edges from 1 again.
- R7: The words are captured on the chip select falling edge. Changes on the sample inputs during a frame do not change the bits sent in that frame.
- R8: The falling-edge counter saturates and does not wrap. However many extra clocks arrive, the lines stay 0 and the track flag stays high until chip select rises.
- R9: The result width W is a parameter. A 12-bit instance places bit 0 on edge 26, and a 16-bit instance places it on edge 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cs_n | input | 1 | Active-low chip select; each low period is one frame |
| sclk | input | 1 | Serial clock; the falling edges advance the frame |
| samp_a | input | RES_BITS | Channel A result word, two's complement |
| samp_b | input | RES_BITS | Channel B result word, two's complement |
| sdo_a | output | 1 | Channel A serial data |
| sdo_a_oe | output | 1 | Output enable for sdo_a; 0 models high impedance |
| sdo_b | output | 1 | Channel B serial data |
| sdo_b_oe | output | 1 | Output enable for sdo_b; 0 models high impedance |
| track_o | output | 1 | High while the track-and-hold is sampling |

## Verification
Falling edge 15 does two things at once: it releases the track-and-hold and it launches the first result bit. A fault in either the flag or the data path could hide behind the other. On every frame the bench samples both the track flag and both data lines just after edge 15, and judges each against its own expectation. The frames use word pairs whose sign bits differ, including a pair with opposite sign bits on A and B, so a line that is stuck or swapped shows up in the same cycle as the flag rises. The bench also rewrites the inputs during the conversion window. The bits that follow must still match the words from the frame start.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  // falling edges spent converting before the first result bit
  localparam int unsigned CONV_EDGES = 14;

  function automatic int unsigned first_bit_edge();
    return CONV_EDGES + 1;
  endfunction

  function automatic int unsigned last_bit_edge(input int unsigned res);
    return CONV_EDGES + res;
  endfunction

  // bit carried on the line after falling edge 'e' for a word of 'res' bits
  function automatic logic pick_bit(input logic [31:0] w,
                                    input int unsigned res,
                                    input int unsigned e);
    logic [31:0] t;
    if (e < first_bit_edge() || e > last_bit_edge(res)) return 1'b0;
    t = w >> (res - (e - CONV_EDGES));
    return t[0];
  endfunction

endpackage

// File: rtl/dsr_edge_counter.sv
module dsr_edge_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             sclk,
  input  logic             cs_n,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic at_max;
  assign at_max = (cnt == CNT_MAX);

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n)        cnt <= '0;
    else if (!at_max) cnt <= cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(negedge sclk) disable iff (cs_n)
    !at_max |=> (cnt == $past(cnt) + 1'b1));                         // R6
  AST_CNT_SATURATE: assert property (@(negedge sclk) disable iff (cs_n)
    at_max |=> at_max);                                              // R8
endmodule

// File: rtl/dsr_word_capture.sv
module dsr_word_capture #(
  parameter int unsigned W = 16
) (
  input  logic         cs_n,
  input  logic         sclk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(negedge cs_n) q_o <= d_i;

  AST_WORD_HELD: assert property (@(negedge sclk) disable iff (cs_n)
    1'b1 |=> $stable(q_o));                                          // R7
endmodule

// File: rtl/dsr_frame_ctrl.sv
module dsr_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int unsigned RES_BITS = 16,
  parameter int unsigned CNT_W    = 5
) (
  input  logic             sclk,
  input  logic             cs_n,
  input  logic [CNT_W-1:0] cnt,
  output logic             oe,
  output logic             track,
  output logic             msb_evt,
  output logic             lsb_evt
);
  localparam logic [CNT_W-1:0] MSB_EDGE = CNT_W'(first_bit_edge());
  localparam logic [CNT_W-1:0] LSB_EDGE = CNT_W'(last_bit_edge(RES_BITS));
  localparam logic [CNT_W-1:0] CONV_CNT = CNT_W'(CONV_EDGES);

  assign oe      = ~cs_n;
  assign msb_evt = (cnt == MSB_EDGE);
  assign lsb_evt = (cnt == LSB_EDGE);
  assign track   = cs_n | (cnt >= MSB_EDGE);

  AST_HOLD_IN_CONV: assert property (@(negedge sclk) disable iff (cs_n)
    (cnt < CONV_CNT) |=> !track);                                    // R2
  AST_TRACK_RISE: assert property (@(negedge sclk) disable iff (cs_n)
    (cnt == CONV_CNT) |=> ($rose(track) && msb_evt));                // R3
  AST_TRACK_KEEP: assert property (@(negedge sclk) disable iff (cs_n)
    track |=> track);                                                // R8
  AST_OE_IN_FRAME: assert property (@(negedge sclk) disable iff (cs_n)
    1'b1 |-> oe);                                                    // R1
endmodule

// File: rtl/dsr_bit_sequencer.sv
module dsr_bit_sequencer
  import adc_frame_pkg::*;
#(
  parameter int unsigned RES_BITS = 16,
  parameter int unsigned CNT_W    = 5
) (
  input  logic                sclk,
  input  logic                cs_n,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                lsb_evt,
  input  logic [RES_BITS-1:0] word,
  output logic                sdo
);
  localparam logic [CNT_W-1:0] CONV_CNT = CNT_W'(CONV_EDGES);

  logic raw_bit;
  always_comb raw_bit = pick_bit(32'(word), RES_BITS, int'(cnt));
  assign sdo = raw_bit & ~cs_n;

  AST_ZERO_IN_CONV: assert property (@(negedge sclk) disable iff (cs_n)
    (cnt < CONV_CNT) |=> !sdo);                                      // R2
  AST_ZERO_AFTER_LSB: assert property (@(negedge sclk) disable iff (cs_n)
    (lsb_evt || !sdo && cnt > CNT_W'(last_bit_edge(RES_BITS))) |=> !sdo); // R5
  AST_SIGN_FIRST: assert property (@(negedge sclk) disable iff (cs_n)
    (cnt == CONV_CNT) |=> (sdo == word[RES_BITS-1]));                // R3
endmodule

// File: rtl/dual_adc_serial_out.sv
module dual_adc_serial_out
  import adc_frame_pkg::*;
#(
  parameter int unsigned RES_BITS = 16
) (
  input  logic                cs_n,
  input  logic                sclk,
  input  logic [RES_BITS-1:0] samp_a,
  input  logic [RES_BITS-1:0] samp_b,
  output logic                sdo_a,
  output logic                sdo_a_oe,
  output logic                sdo_b,
  output logic                sdo_b_oe,
  output logic                track_o
);
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CNT_W  = $clog2(CONV_EDGES + RES_BITS + 2);

  logic [CNT_W-1:0]    edge_cnt;
  logic                frame_oe;
  logic                msb_evt;
  logic                lsb_evt;
  logic [RES_BITS-1:0] samp_in  [NUM_CH];
  logic [RES_BITS-1:0] samp_lat [NUM_CH];
  logic                line_q   [NUM_CH];

  assign samp_in[0] = samp_a;
  assign samp_in[1] = samp_b;

  dsr_edge_counter #(.CNT_W(CNT_W)) cnt_i (
    .sclk(sclk), .cs_n(cs_n), .cnt(edge_cnt)
  );

  dsr_frame_ctrl #(.RES_BITS(RES_BITS), .CNT_W(CNT_W)) ctrl_i (
    .sclk(sclk), .cs_n(cs_n), .cnt(edge_cnt), .oe(frame_oe),
    .track(track_o), .msb_evt(msb_evt), .lsb_evt(lsb_evt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dsr_word_capture #(.W(RES_BITS)) cap_i (
      .cs_n(cs_n), .sclk(sclk), .d_i(samp_in[c]), .q_o(samp_lat[c])
    );
    dsr_bit_sequencer #(.RES_BITS(RES_BITS), .CNT_W(CNT_W)) seq_i (
      .sclk(sclk), .cs_n(cs_n), .cnt(edge_cnt), .lsb_evt(lsb_evt),
      .word(samp_lat[c]), .sdo(line_q[c])
    );
  end

  assign sdo_a    = line_q[0];
  assign sdo_b    = line_q[1];
  assign sdo_a_oe = frame_oe;
  assign sdo_b_oe = frame_oe;

  AST_IDLE_RELEASED: assert property (@(posedge sclk)
    cs_n |-> (!sdo_a_oe && !sdo_b_oe && !sdo_a && !sdo_b && track_o)); // R6
  AST_MSB_WITH_TRACK: assert property (@(negedge sclk) disable iff (cs_n)
    msb_evt |-> track_o);                                            // R3
endmodule

// File: tb/dual_adc_serial_out_tb.sv
module dual_adc_serial_out_tb_top;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [15:0] samp_a = '0, samp_b = '0;
  logic [11:0] s12_a = '0, s12_b = '0;
  logic        sdo_a, sdo_a_oe, sdo_b, sdo_b_oe, track_o;
  logic        t_a, t_a_oe, t_b, t_b_oe, t_track;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] lfsr = 32'h1D87_2B41;

  always #4 sclk = ~sclk;

  dual_adc_serial_out #(.RES_BITS(16)) dut_i (
    .cs_n(cs_n), .sclk(sclk), .samp_a(samp_a), .samp_b(samp_b),
    .sdo_a(sdo_a), .sdo_a_oe(sdo_a_oe), .sdo_b(sdo_b), .sdo_b_oe(sdo_b_oe),
    .track_o(track_o));

  dual_adc_serial_out #(.RES_BITS(12)) dut12_i (
    .cs_n(cs_n), .sclk(sclk), .samp_a(s12_a), .samp_b(s12_b),
    .sdo_a(t_a), .sdo_a_oe(t_a_oe), .sdo_b(t_b), .sdo_b_oe(t_b_oe),
    .track_o(t_track));

  task automatic check(input string req, input logic act, input logic exp, input int k);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s edge %0d: actual %b expected %b", req, k, act, exp);
    end
  endtask

  // expected line value: shift the word so the wanted bit reaches the top
  function automatic logic want(input logic [15:0] w, input int res, input int k);
    logic [15:0] s;
    if (k < 15 || k >= 15 + res) return 1'b0;
    s = (w << (16 - res)) << (k - 15);
    return s[15];
  endfunction

  task automatic run_frame(input logic [15:0] a, input logic [15:0] b,
                           input int edges, input bit disturb);
    logic [11:0] a12, b12;
    a12 = a[11:0] ^ b[15:4];
    b12 = b[11:0];
    samp_a = a; samp_b = b; s12_a = a12; s12_b = b12;
    @(posedge sclk); #1;
    cs_n = 1'b0;
    #1;
    check("R1", sdo_a_oe & sdo_b_oe, 1'b1, 0);
    check("R1", sdo_a | sdo_b, 1'b0, 0);
    for (int k = 1; k <= edges; k++) begin
      @(negedge sclk); #2;
      if (k == 3 && disturb) begin
        samp_a = ~a; samp_b = ~b; s12_a = ~a12; s12_b = ~b12;
      end
      if (k <= 14) begin
        check("R2", sdo_a, 1'b0, k); check("R2", track_o, 1'b0, k);
      end else if (k == 15) begin
        check("R3", track_o, 1'b1, k);
        check("R3", sdo_a, a[15], k); check("R3", sdo_b, b[15], k);
      end else if (k <= 30) begin
        check(disturb ? "R7" : "R4", sdo_a, want(a, 16, k), k);
        check(disturb ? "R7" : "R4", sdo_b, want(b, 16, k), k);
      end else begin
        check(k > 31 ? "R8" : "R5", sdo_a | sdo_b, 1'b0, k);
        check(k > 31 ? "R8" : "R5", track_o, 1'b1, k);
      end
      check("R9", t_a, want({4'h0, a12}, 12, k), k);
      check("R9", t_b, want({4'h0, b12}, 12, k), k);
      check("R9", t_track, (k >= 15) ? 1'b1 : 1'b0, k);
    end
    @(posedge sclk); #1;
    cs_n = 1'b1;
    #1;
    check("R6", sdo_a_oe | sdo_b_oe | t_a_oe | t_b_oe, 1'b0, 0);
    check("R6", sdo_a | sdo_b | t_a | t_b, 1'b0, 0);
    check("R6", track_o & t_track, 1'b1, 0);
    @(posedge sclk); #1;
  endtask

  initial begin
    #1;
    check("R6", sdo_a_oe | sdo_b_oe, 1'b0, 0);
    check("R6", track_o, 1'b1, 0);
    run_frame(16'h8000, 16'h7FFF, 32, 0);
    run_frame(16'hFFFF, 16'h0000, 32, 0);
    run_frame(16'hAAAA, 16'h5555, 32, 0);
    for (int i = 0; i < 16; i++)
      run_frame(16'(1) << i, ~(16'(1) << i), 32, 0);
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_frame(lfsr[15:0], lfsr[31:16], 32, (i % 4) == 1);
    end
    run_frame(16'hC3A5, 16'h3C5A, 72, 0);
    run_frame(16'h1234, 16'hEDCB, 33, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule